// File: doc/BRIEF.md
# Vector Unpack Engine

The block carries out one unpack command at a time. A command names a start address in a 128-bit vector memory, a count of vectors, an element size, a lane count and a pair of cycle controls. The block pulls packed elements from a 32-bit operand stream and widens each to 32 bits. It merges them into the vector already held at the target address and writes the result back. The merge is a read-modify-write, so each written vector is first read from memory, and the lanes above the command's lane count keep their old contents.

The two cycle controls set the address pattern. When the write length is at most the cycle length, only the leading slots of each cycle are written and the others are stepped over. When the write length is longer, every slot is written. The leading slots take stream data and the trailing slots are filled with zero. Each written vector also produces a tracking word at the same address. The tracking word holds the stream address of the word that supplied the vector's first element.

Memory words are little-endian. A build parameter inserts a byte reversal within each 32-bit lane on both the read path and the write path, for hosts whose lane order differs. At its default setting, data passes through unchanged.

Top module: `vec_unpack`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `mem_rd_en`, `mem_wr_en`, `trk_wr_en` and `str_ready` are 0.
- R2: The immediate sets the start address. Bits [AW-1:0] give the address. When bit 15 is set, `rel_base` is added to it, and when bit 15 is clear `rel_base` has no effect. The address wraps modulo 2^AW and advances by one for every slot, including skipped slots.
- R3: The element size code gives the element width: 0 is 32 bits, 1 is 16 bits, 2 is 8 bits and 3 is 1 bit. Elements are taken from each 32-bit stream word starting at bit 0. Lane i receives the i-th element of the vector, and a new stream word is fetched only after the previous word is exhausted.
- R4: An element is zero-extended when immediate bit 14 is set, or when the element width is 1 bit. Otherwise it is sign-extended from its top bit.
- R5: Lanes 0 to `cmd_vn` are replaced. Higher lanes keep the value read from the same address before the write, and every memory write is preceded by a read of that same address.
- R6: When WL <= CL, slots at position WL to CL-1 of each CL-slot cycle are skipped: they are neither read nor written, and they consume no stream data.
- R7: When WL > CL, every slot is written. Slots at position CL to WL-1 of each WL-slot cycle write zero into lanes 0 to `cmd_vn` and take no stream data.
- R8: A command writes exactly `cmd_num` vectors, with 0 meaning 256. Skipped slots do not count. `cmd_ready` then returns to 1.
- R9: Stream bits left unused in the last word of a command are discarded. The next command starts with a fresh word.
- R10: Each vector write is paired with a tracking write to the same address. The tracking data is the `str_addr` of the word that supplied lane 0, or 0 for a zero-filled vector.
- R11: While a command runs, `cmd_ready` is 0. At most one of memory read, memory write and stream acceptance is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command accepted when valid |
| cmd_imm | input | 16 | Start address and flag bits |
| cmd_num | input | NUM_W | Vector count, 0 = 2^NUM_W |
| cmd_vn | input | log2(LANES) | Index of the highest lane replaced |
| cmd_esz | input | 2 | Element size code |
| cyc_cl | input | CYC_W | Cycle length |
| cyc_wl | input | CYC_W | Write length |
| rel_base | input | AW | Offset added when the relative flag is set |
| str_valid | input | 1 | Stream word present |
| str_ready | output | 1 | Stream word taken this cycle when valid |
| str_data | input | 32 | Stream word |
| str_addr | input | SAW | Source address of the stream word |
| mem_rd_en | output | 1 | Vector read request |
| mem_rd_addr | output | AW | Vector read address |
| mem_rd_data | input | LANES*32 | Read data, one cycle after the request |
| mem_wr_en | output | 1 | Vector write strobe |
| mem_wr_addr | output | AW | Vector write address |
| mem_wr_data | output | LANES*32 | Vector write data |
| trk_wr_en | output | 1 | Tracking write strobe |
| trk_wr_addr | output | AW | Tracking write address |
| trk_wr_data | output | SAW | Tracking word |

## Verification
The bench runs the main function with all four element sizes. Full-width elements show whether lanes are ordered correctly. Negative 16-bit and 8-bit elements, with the unsigned flag set and with it clear, separate sign extension from zero extension. The 1-bit case shows that the width rule takes precedence over the flag.

Commands whose lane count is below the full vector show whether old memory contents are preserved. The cycle tests use equal lengths, a skipping pattern and two zero-filling patterns, and these tell apart the address stepping, the stream consumption and the fill values. Further cases use a relative address that wraps past the top of memory, a zero count meaning 256, and back-to-back commands that leave bits unused in a word, which shows whether leftover bits are discarded.

// File: rtl/vec_unpack_pkg.sv
package vec_unpack_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_SLOT = 3'd1,
      ST_RD   = 3'd2,
      ST_CAP  = 3'd3,
      ST_GATH = 3'd4,
      ST_WR   = 3'd5
   } vu_state_e;

   localparam int unsigned VU_WORD_W = 32;
   localparam int unsigned VU_R_BIT  = 15;
   localparam int unsigned VU_U_BIT  = 14;

   // element width in bits for a size code
   function automatic logic [5:0] vu_esz_bits(input logic [1:0] code);
      case (code)
         2'd0:    vu_esz_bits = 6'd32;
         2'd1:    vu_esz_bits = 6'd16;
         2'd2:    vu_esz_bits = 6'd8;
         default: vu_esz_bits = 6'd1;
      endcase
   endfunction

endpackage

// File: rtl/unp_bitbuf.sv
module unp_bitbuf
   import vec_unpack_pkg::*;
#(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned SAW    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              want,
   input  logic [1:0]        esz,
   input  logic              str_valid,
   output logic              str_ready,
   input  logic [WORD_W-1:0] str_data,
   input  logic [SAW-1:0]    str_addr,
   output logic              take,
   output logic [WORD_W-1:0] elem_raw,
   output logic [SAW-1:0]    word_src
);
   localparam int unsigned CW = $clog2(WORD_W) + 1;

   if (WORD_W != VU_WORD_W) begin : g_bad_word
      $error("unp_bitbuf: WORD_W must equal 32");
   end

   logic [WORD_W-1:0] sr_q;
   logic [CW-1:0]     cnt_q;
   logic [SAW-1:0]    src_q;
   logic [CW-1:0]     step;

   assign step      = CW'(vu_esz_bits(esz));
   assign str_ready = want && (cnt_q == '0);
   assign take      = want && (cnt_q != '0);
   assign word_src  = src_q;

   always_comb begin
      case (esz)
         2'd0:    elem_raw = sr_q;
         2'd1:    elem_raw = {{(WORD_W-16){1'b0}}, sr_q[15:0]};
         2'd2:    elem_raw = {{(WORD_W-8){1'b0}}, sr_q[7:0]};
         default: elem_raw = {{(WORD_W-1){1'b0}}, sr_q[0]};
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr_q  <= '0;
         cnt_q <= '0;
         src_q <= '0;
      end else if (flush) begin
         cnt_q <= '0;
      end else if (str_ready && str_valid) begin
         sr_q  <= str_data;
         cnt_q <= CW'(WORD_W);
         src_q <= str_addr;
      end else if (take) begin
         sr_q  <= sr_q >> step;
         cnt_q <= cnt_q - step;
      end
   end

endmodule

// File: rtl/unp_widen.sv
module unp_widen #(
   parameter int unsigned LANE_W = 32
) (
   input  logic [LANE_W-1:0] raw,
   input  logic [1:0]        esz,
   input  logic              usn,
   output logic [LANE_W-1:0] wide
);
   if (LANE_W != 32) begin : g_bad_lane
      $error("unp_widen: LANE_W must equal 32");
   end

   always_comb begin
      case (esz)
         2'd0:    wide = raw;
         2'd1:    wide = {{(LANE_W-16){raw[15] & ~usn}}, raw[15:0]};
         2'd2:    wide = {{(LANE_W-8){raw[7] & ~usn}}, raw[7:0]};
         default: wide = {{(LANE_W-1){1'b0}}, raw[0]};
      endcase
   end

endmodule

// File: rtl/unp_slot_seq.sv
module unp_slot_seq #(
   parameter int unsigned CYC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CYC_W-1:0] cl_in,
   input  logic [CYC_W-1:0] wl_in,
   input  logic             adv,
   output logic             slot_skip,
   output logic             slot_zero
);
   logic [CYC_W-1:0] cl_q, wl_q, pos_q, period, cl_eff, wl_eff;
   logic             fill_q;

   assign cl_eff    = (cl_in == '0) ? CYC_W'(1) : cl_in;
   assign wl_eff    = (wl_in == '0) ? CYC_W'(1) : wl_in;
   assign period    = fill_q ? wl_q : cl_q;
   assign slot_skip = !fill_q && (pos_q >= wl_q);
   assign slot_zero = fill_q && (pos_q >= cl_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cl_q   <= CYC_W'(1);
         wl_q   <= CYC_W'(1);
         pos_q  <= '0;
         fill_q <= 1'b0;
      end else if (load) begin
         cl_q   <= cl_eff;
         wl_q   <= wl_eff;
         fill_q <= wl_eff > cl_eff;
         pos_q  <= '0;
      end else if (adv) begin
         pos_q  <= (pos_q == period - 1'b1) ? '0 : pos_q + 1'b1;
      end
   end

endmodule

// File: rtl/unp_lane_order.sv
module unp_lane_order #(
   parameter int unsigned LANES      = 4,
   parameter int unsigned LANE_W     = 32,
   parameter bit          SWAP_BYTES = 1'b0
) (
   input  logic [LANES*LANE_W-1:0] din,
   output logic [LANES*LANE_W-1:0] dout
);
   localparam int unsigned NBYTES = LANE_W / 8;

   if (SWAP_BYTES) begin : g_swap
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         for (genvar b = 0; b < NBYTES; b++) begin : g_byte
            assign dout[l*LANE_W + b*8 +: 8] =
               din[l*LANE_W + (NBYTES-1-b)*8 +: 8];
         end
      end
   end else begin : g_pass
      assign dout = din;
   end

endmodule

// File: rtl/vec_unpack.sv
module vec_unpack
   import vec_unpack_pkg::*;
#(
   parameter int unsigned AW         = 10,
   parameter int unsigned NUM_W      = 8,
   parameter int unsigned CYC_W      = 8,
   parameter int unsigned SAW        = 32,
   parameter int unsigned LANES      = 4,
   parameter int unsigned LANE_W     = 32,
   parameter bit          SWAP_BYTES = 1'b0,
   localparam int unsigned LIDX_W    = $clog2(LANES),
   localparam int unsigned VEC_W     = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [15:0]       cmd_imm,
   input  logic [NUM_W-1:0]  cmd_num,
   input  logic [LIDX_W-1:0] cmd_vn,
   input  logic [1:0]        cmd_esz,
   input  logic [CYC_W-1:0]  cyc_cl,
   input  logic [CYC_W-1:0]  cyc_wl,
   input  logic [AW-1:0]     rel_base,
   input  logic              str_valid,
   output logic              str_ready,
   input  logic [31:0]       str_data,
   input  logic [SAW-1:0]    str_addr,
   output logic              mem_rd_en,
   output logic [AW-1:0]     mem_rd_addr,
   input  logic [VEC_W-1:0]  mem_rd_data,
   output logic              mem_wr_en,
   output logic [AW-1:0]     mem_wr_addr,
   output logic [VEC_W-1:0]  mem_wr_data,
   output logic              trk_wr_en,
   output logic [AW-1:0]     trk_wr_addr,
   output logic [SAW-1:0]    trk_wr_data
);
   localparam int unsigned LEFT_W = NUM_W + 1;

   if (AW > VU_U_BIT) begin : g_bad_aw
      $error("vec_unpack: AW overlaps the flag bits");
   end
   if (LANES < 2 || (1 << LIDX_W) != LANES) begin : g_bad_lanes
      $error("vec_unpack: LANES must be a power of two");
   end

   vu_state_e                    state_q;
   logic [AW-1:0]                addr_q, start_addr;
   logic [LEFT_W-1:0]            left_q;
   logic [LIDX_W-1:0]            vn_q, lane_q;
   logic [1:0]                   esz_q;
   logic                         usn_q;
   logic [SAW-1:0]               trk_q;
   logic [LANES-1:0][LANE_W-1:0] vec_q;
   logic [LANES-1:0][LANE_W-1:0] old_lanes;
   logic [VEC_W-1:0]             old_host, vec_flat;
   logic                         accept, slot_skip, slot_zero, seq_adv;
   logic                         take;
   logic [LANE_W-1:0]            elem_raw, elem_wide;
   logic [SAW-1:0]               word_src;
   logic                         unused_imm;

   assign unused_imm = ^cmd_imm[VU_U_BIT-1:AW];
   assign accept     = (state_q == ST_IDLE) && cmd_valid;
   assign start_addr = cmd_imm[AW-1:0] + (cmd_imm[VU_R_BIT] ? rel_base : '0);
   assign seq_adv    = ((state_q == ST_SLOT) && slot_skip) || (state_q == ST_WR);

   unp_slot_seq #(.CYC_W(CYC_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .cl_in     (cyc_cl),
      .wl_in     (cyc_wl),
      .adv       (seq_adv),
      .slot_skip (slot_skip),
      .slot_zero (slot_zero)
   );

   unp_bitbuf #(.WORD_W(32), .SAW(SAW)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (accept),
      .want      (state_q == ST_GATH),
      .esz       (esz_q),
      .str_valid (str_valid),
      .str_ready (str_ready),
      .str_data  (str_data),
      .str_addr  (str_addr),
      .take      (take),
      .elem_raw  (elem_raw),
      .word_src  (word_src)
   );

   unp_widen #(.LANE_W(LANE_W)) u_widen (
      .raw  (elem_raw),
      .esz  (esz_q),
      .usn  (usn_q),
      .wide (elem_wide)
   );

   unp_lane_order #(.LANES(LANES), .LANE_W(LANE_W), .SWAP_BYTES(SWAP_BYTES)) u_rd_order (
      .din  (mem_rd_data),
      .dout (old_host)
   );

   assign vec_flat = vec_q;

   unp_lane_order #(.LANES(LANES), .LANE_W(LANE_W), .SWAP_BYTES(SWAP_BYTES)) u_wr_order (
      .din  (vec_flat),
      .dout (mem_wr_data)
   );

   assign old_lanes = old_host;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         left_q  <= '0;
         vn_q    <= '0;
         lane_q  <= '0;
         esz_q   <= '0;
         usn_q   <= 1'b0;
         trk_q   <= '0;
         vec_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (cmd_valid) begin
                  addr_q  <= start_addr;
                  left_q  <= (cmd_num == '0) ? {1'b1, {NUM_W{1'b0}}} : {1'b0, cmd_num};
                  vn_q    <= cmd_vn;
                  esz_q   <= cmd_esz;
                  usn_q   <= cmd_imm[VU_U_BIT];
                  state_q <= ST_SLOT;
               end
            end
            ST_SLOT: begin
               if (slot_skip) addr_q  <= addr_q + 1'b1;
               else           state_q <= ST_RD;
            end
            ST_RD: state_q <= ST_CAP;
            ST_CAP: begin
               lane_q <= '0;
               for (int l = 0; l < LANES; l++) begin
                  vec_q[l] <= (slot_zero && (LIDX_W'(l) <= vn_q)) ? '0 : old_lanes[l];
               end
               if (slot_zero) begin
                  trk_q   <= '0;
                  state_q <= ST_WR;
               end else begin
                  state_q <= ST_GATH;
               end
            end
            ST_GATH: begin
               if (take) begin
                  vec_q[lane_q] <= elem_wide;
                  if (lane_q == '0) trk_q <= word_src;
                  if (lane_q == vn_q) state_q <= ST_WR;
                  else                lane_q  <= lane_q + 1'b1;
               end
            end
            ST_WR: begin
               addr_q  <= addr_q + 1'b1;
               left_q  <= left_q - 1'b1;
               state_q <= (left_q == LEFT_W'(1)) ? ST_IDLE : ST_SLOT;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cmd_ready   = (state_q == ST_IDLE);
   assign mem_rd_en   = (state_q == ST_RD);
   assign mem_rd_addr = addr_q;
   assign mem_wr_en   = (state_q == ST_WR);
   assign mem_wr_addr = addr_q;
   assign trk_wr_en   = (state_q == ST_WR);
   assign trk_wr_addr = addr_q;
   assign trk_wr_data = trk_q;

endmodule

// File: rtl/vec_unpack_chk.sv
module vec_unpack_chk #(
   parameter int unsigned AW = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_valid,
   input logic          cmd_ready,
   input logic          str_ready,
   input logic          mem_rd_en,
   input logic [AW-1:0] mem_rd_addr,
   input logic          mem_wr_en,
   input logic [AW-1:0] mem_wr_addr,
   input logic          trk_wr_en,
   input logic [AW-1:0] trk_wr_addr
);
   logic          rd_seen_q;
   logic [AW-1:0] rd_addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_seen_q <= 1'b0;
         rd_addr_q <= '0;
      end else if (mem_rd_en) begin
         rd_seen_q <= 1'b1;
         rd_addr_q <= mem_rd_addr;
      end else if (mem_wr_en) begin
         rd_seen_q <= 1'b0;
      end
   end

   AST_READ_BEFORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> (rd_seen_q && rd_addr_q == mem_wr_addr)); // R5
   AST_TRACK_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> (trk_wr_en && trk_wr_addr == mem_wr_addr)); // R10
   AST_TRACK_ONLY_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      trk_wr_en |-> mem_wr_en); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> !(mem_rd_en || mem_wr_en || str_ready)); // R11
   AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd_en, mem_wr_en, str_ready})); // R11
   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_ready && cmd_valid) |=> !cmd_ready); // R11

endmodule

bind vec_unpack vec_unpack_chk #(.AW(AW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_valid   (cmd_valid),
   .cmd_ready   (cmd_ready),
   .str_ready   (str_ready),
   .mem_rd_en   (mem_rd_en),
   .mem_rd_addr (mem_rd_addr),
   .mem_wr_en   (mem_wr_en),
   .mem_wr_addr (mem_wr_addr),
   .trk_wr_en   (trk_wr_en),
   .trk_wr_addr (trk_wr_addr)
);

// File: tb/vec_unpack_bench.sv
`timescale 1ns/1ps
module vec_unpack_bench;
   localparam int AW = 10;
   localparam int DEPTH = 1 << AW;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmd_valid = 1'b0;
   logic         cmd_ready;
   logic [15:0]  cmd_imm = '0;
   logic [7:0]   cmd_num = '0;
   logic [1:0]   cmd_vn = '0;
   logic [1:0]   cmd_esz = '0;
   logic [7:0]   cyc_cl = 8'd1;
   logic [7:0]   cyc_wl = 8'd1;
   logic [AW-1:0] rel_base = '0;
   logic         str_valid;
   logic         str_ready;
   logic [31:0]  str_data;
   logic [31:0]  str_addr;
   logic         mem_rd_en;
   logic [AW-1:0] mem_rd_addr;
   logic [127:0] mem_rd_data;
   logic         mem_wr_en;
   logic [AW-1:0] mem_wr_addr;
   logic [127:0] mem_wr_data;
   logic         trk_wr_en;
   logic [AW-1:0] trk_wr_addr;
   logic [31:0]  trk_wr_data;

   always #2.5 clk = ~clk;

   vec_unpack u_vec_unpack (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_imm(cmd_imm), .cmd_num(cmd_num), .cmd_vn(cmd_vn), .cmd_esz(cmd_esz),
      .cyc_cl(cyc_cl), .cyc_wl(cyc_wl), .rel_base(rel_base),
      .str_valid(str_valid), .str_ready(str_ready), .str_data(str_data), .str_addr(str_addr),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
      .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .trk_wr_en(trk_wr_en), .trk_wr_addr(trk_wr_addr), .trk_wr_data(trk_wr_data)
   );

   typedef struct {
      logic [AW-1:0] a;
      logic [127:0]  d;
      logic [31:0]   t;
      string         req;
   } exp_t;
   typedef struct {
      logic [31:0] d;
      logic [31:0] a;
   } sw_t;

   exp_t         exq[$];
   sw_t          sq[$];
   int           ex_rd = 0;
   int           sq_rd = 0;
   logic [127:0] mem [DEPTH];
   logic [127:0] smem [DEPTH];
   logic [127:0] rd_q = '0;
   int           main_cmp = 0, main_bad = 0;
   int           mon_cmp = 0, mon_bad = 0;
   logic [31:0]  rs = 32'h1ACE_B00C;
   logic [31:0]  src_next = 32'h0001_0000;

   function automatic logic [127:0] init_vec(int i);
      logic [31:0] u;
      u = 32'(i);
      return {u * 32'h9E37_79B1, ~u, u ^ 32'h5A5A_0000, u + 32'h1234};
   endfunction

   function automatic logic [31:0] widen(logic [31:0] raw, int w, bit usn);
      logic [31:0] mask, v;
      mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
      v = raw & mask;
      if (usn || w == 1) return v;
      if (v[w-1]) return v | ~mask;
      return v;
   endfunction

   function automatic int esz_width(int code);
      case (code)
         0: return 32;
         1: return 16;
         2: return 8;
         default: return 1;
      endcase
   endfunction

   // memory model, one-cycle read latency, and stream consumer
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= init_vec(i);
      end else begin
         if (mem_rd_en) rd_q <= mem[mem_rd_addr];
         if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;
         if (str_valid && str_ready) sq_rd <= sq_rd + 1;
      end
   end
   assign mem_rd_data = rd_q;

   always_comb begin
      str_valid = (sq_rd < sq.size());
      str_data  = str_valid ? sq[sq_rd].d : 32'h0;
      str_addr  = str_valid ? sq[sq_rd].a : 32'h0;
   end

   // monitor: pops expected writes and compares
   always @(negedge clk) begin
      if (rst_n && mem_wr_en) begin
         mon_cmp++;
         if (ex_rd >= exq.size()) begin
            mon_bad++;
            $display("FAIL R6 unexpected write: actual addr %0d, expected no write", mem_wr_addr);
         end else begin
            if (mem_wr_addr !== exq[ex_rd].a || mem_wr_data !== exq[ex_rd].d) begin
               mon_bad++;
               $display("FAIL %s write: actual %0d/%h expected %0d/%h", exq[ex_rd].req,
                        mem_wr_addr, mem_wr_data, exq[ex_rd].a, exq[ex_rd].d);
            end
            mon_cmp++;
            if (trk_wr_en !== 1'b1 || trk_wr_addr !== exq[ex_rd].a || trk_wr_data !== exq[ex_rd].t) begin
               mon_bad++;
               $display("FAIL R10 tracking: actual %b/%0d/%h expected 1/%0d/%h", trk_wr_en,
                        trk_wr_addr, trk_wr_data, exq[ex_rd].a, exq[ex_rd].t);
            end
         end
         ex_rd <= ex_rd + 1;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
      main_cmp++;
      if (!ok) begin
         main_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic run_cmd(input logic [15:0] imm, input int num, input int vn,
                          input int esz, input int cl, input int wl,
                          input logic [AW-1:0] base, input string req);
      int n, pos, wr, per, w, rem;
      bit fill, usn, skip, zf;
      logic [AW-1:0] a;
      logic [31:0] cw, ca, tk, e;
      logic [127:0] nv;
      n = (num == 0) ? 256 : num;
      a = imm[AW-1:0] + (imm[15] ? base : '0);
      fill = wl > cl;
      per = fill ? wl : cl;
      w = esz_width(esz);
      usn = imm[14];
      pos = 0; wr = 0; rem = 0; cw = 0; ca = 0;
      while (wr < n) begin
         skip = !fill && pos >= wl;
         zf = fill && pos >= cl;
         if (!skip) begin
            nv = smem[a];
            tk = 32'h0;
            for (int l = 0; l <= vn; l++) begin
               if (zf) begin
                  e = 32'h0;
               end else begin
                  if (rem == 0) begin
                     rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
                     cw = rs; ca = src_next; src_next = src_next + 32'd4;
                     sq.push_back('{d: cw, a: ca});
                     rem = 32;
                  end
                  if (l == 0) tk = ca;
                  e = widen(cw >> (32 - rem), w, usn);
                  rem = rem - w;
               end
               nv[l*32 +: 32] = e;
            end
            smem[a] = nv;
            exq.push_back('{a: a, d: nv, t: tk, req: req});
            wr++;
         end
         a = a + 1'b1;
         pos = (pos + 1) % per;
      end
      @(negedge clk);
      cmd_imm = imm; cmd_num = 8'(num); cmd_vn = 2'(vn); cmd_esz = 2'(esz);
      cyc_cl = 8'(cl); cyc_wl = 8'(wl); rel_base = base; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      check(cmd_ready == 1'b0, "R11", "ready low while busy", 32'(cmd_ready), 0);
      while (!cmd_ready) @(negedge clk);
      check(ex_rd == exq.size(), "R8", "vectors written", 32'(ex_rd), 32'(exq.size()));
      check(sq_rd == sq.size(), "R9", "stream words taken", 32'(sq_rd), 32'(sq.size()));
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) smem[i] = init_vec(i);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(cmd_ready == 1'b1, "R1", "reset ready", 32'(cmd_ready), 1);
      check({mem_rd_en, mem_wr_en, trk_wr_en, str_ready} == 4'b0, "R1", "reset strobes",
            32'({mem_rd_en, mem_wr_en, trk_wr_en, str_ready}), 0);
      run_cmd(16'd40,            3, 3, 0, 1, 1, '0, "R3");    // 32-bit lanes
      run_cmd(16'd60,            4, 3, 1, 1, 1, '0, "R4");    // 16-bit signed
      run_cmd(16'h4000 | 16'd80, 3, 2, 2, 1, 1, '0, "R5");    // 8-bit unsigned, lane 3 kept
      run_cmd(16'd100,           5, 3, 3, 1, 1, '0, "R4");    // 1-bit always zero-extended
      run_cmd(16'd140,           4, 1, 2, 1, 1, '0, "R5");    // 8-bit signed, two lanes
      run_cmd(16'd200,           5, 1, 1, 4, 2, '0, "R6");    // skipping
      run_cmd(16'd260,           6, 3, 1, 3, 3, '0, "R6");    // equal lengths
      run_cmd(16'd300,           6, 1, 2, 1, 3, '0, "R7");    // zero fill
      run_cmd(16'd350,           7, 3, 0, 2, 5, '0, "R7");
      run_cmd(16'h8000 | 16'd1020, 4, 3, 1, 1, 1, 10'd2, "R2"); // relative, wraps
      run_cmd(16'd500,           2, 3, 0, 1, 1, 10'd77, "R2"); // base ignored
      run_cmd(16'd600,           0, 0, 3, 1, 1, '0, "R8");    // 256 vectors
      run_cmd(16'd900,           5, 0, 3, 1, 1, '0, "R9");    // leaves bits unused
      run_cmd(16'd910,           2, 0, 2, 1, 1, '0, "R9");
      repeat (3) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***",
               main_cmp + mon_cmp, main_bad + mon_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog: actual run still busy, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***",
               main_cmp + mon_cmp + 1, main_bad + mon_bad + 1);
      $finish;
   end

endmodule